// File: doc/BRIEF.md
# Half-Duplex Two-Wire Serial Port

This block is the device side of a serial port for a converter-style peripheral. One bidirectional data pin carries host writes into the device and device reads back to the host. An active-low SYNC frames the exchange, and the host supplies SCLK. SCLK, SYNC and the incoming data level are brought into the system clock domain through two-flop synchronizers. SCLK edges are then detected there, so SCLK must run at no more than a quarter of the system clock rate.

The pin direction flips each time a 16-bit word completes. After a write word the block drives a read word, which is loaded from `rd_data_i` when it starts. After the read word the pin returns to input. SYNC may be pulsed around each word, or held low for good, in which case write and read words simply alternate. A valid write word updates a 16-bit control register. It can also request a one-cycle conversion-start pulse, or open a calibration burst of one to three words. During a burst the pin direction is held fixed, and the burst cannot be cut short.

Top module: `twp_port`

## Requirements
- R1: On each rising SCLK edge while SYNC is low and the pin is an input, the pin level is shifted in, most significant bit first. After 16 such edges the word appears on `wr_word_o` with a one-cycle `wr_valid_o`.
- R2: The 16th rising SCLK edge of a write word turns the pin into an output. Until then `dio_oe_o` stays low.
- R3: While SYNC is high, `dio_oe_o` is low.
- R4: A read word is loaded from `rd_data_i` when it starts. Bit 15 appears on `dio_o` after the first falling SCLK edge, and each later bit after each following falling edge. Changes on `rd_data_i` after the load do not alter the word being sent.
- R5: Outside a burst, the 16th rising SCLK edge of a read word returns the pin to input, so `dio_oe_o` stays low even with SYNC low.
- R6: With SYNC held low for good, the driver is never turned off during a read word. Write and read words alternate at each 16th rising edge.
- R7: A write word with bit 15 clear is rejected. The control register keeps its value, no conversion starts and no burst opens, but the pin still turns to output for one read word. A word with bit 15 set is copied whole to `ctrl_o`.
- R8: A valid write word with bit 14 set produces exactly one single-cycle `conv_start_o` pulse.
- R9: A valid write word with burst count K in bits 13:12 (K nonzero) and bit 11 set is a read burst. The pin stays an output for K read words, each loaded from `rd_data_i` at its own start, and then returns to input.
- R10: A valid write word with nonzero K and bit 11 clear is a write burst. The next K write words keep the pin an input. They are flagged by `wr_cal_o` and change neither `ctrl_o` nor `conv_start_o`. One read word follows them.
- R11: SYNC going high in the middle of a word discards the bits received so far. The remaining burst word count is left unchanged.
- R12: After reset `dio_oe_o`, `ctrl_o`, `conv_start_o`, `wr_valid_o` and `wr_cal_o` are all zero and the pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| sync_n_i | input | 1 | Active-low frame select |
| dio_i | input | 1 | Level seen on the shared data pin |
| dio_o | output | 1 | Value driven onto the data pin |
| dio_oe_o | output | 1 | Driver enable for the data pin |
| rd_data_i | input | 16 | Word supplied for each read |
| ctrl_o | output | 16 | Control register contents |
| conv_start_o | output | 1 | One-cycle conversion-start pulse |
| wr_word_o | output | 16 | Last completed write word |
| wr_valid_o | output | 1 | Pulse marking a completed write word |
| wr_cal_o | output | 1 | Marks the completed word as burst data |

## Verification
Suppose the bit counter or the direction flag holds a wrong value. At the next word boundary, which is at most sixteen SCLK periods away, `dio_oe_o` then rises during a write or stays low during a read, and the host sees a corrupted read word. A wrong remaining-burst count shows up one word early or late, as an unexpected change of pin direction or as a burst word that leaks into `ctrl_o`. Any shift or load fault in the transmit path shows up within the current read word, as a miscompared bit on `dio_o`.

// File: rtl/twp_pkg.sv
package twp_pkg;
    localparam int WORD_BITS = 16;
    localparam int MODE_POS  = 15;  // must be 1 for an accepted write
    localparam int CONV_POS  = 14;  // conversion start request
    localparam int CNT_HI    = 13;  // burst word count, upper bit
    localparam int CNT_LO    = 12;  // burst word count, lower bit
    localparam int BDIR_POS  = 11;  // 1: read burst, 0: write burst
    localparam int CNT_W     = CNT_HI - CNT_LO + 1;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } pin_dir_e;
endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/twp_shift.sv
module twp_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         rx_bit,
    input  logic         tx_load,
    input  logic [W-1:0] tx_data,
    input  logic         tx_shift,
    output logic [W-1:0] rx_next_o,
    output logic         tx_bit_o
);
    typedef struct packed {
        logic [W-1:0] rx;
        logic [W-1:0] tx;
        logic         dout;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rx_en) sh_d.rx = rx_next_o;
        if (tx_load) begin
            sh_d.tx = tx_data;
        end else if (tx_shift) begin
            sh_d.dout = sh_q.tx[W-1];
            sh_d.tx   = {sh_q.tx[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rx_next_o = {sh_q.rx[W-2:0], rx_bit};
    assign tx_bit_o  = sh_q.dout;
endmodule

// File: rtl/twp_port.sv
module twp_port
    import twp_pkg::*;
#(
    parameter int WORD_W = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              dio_i,
    output logic              dio_o,
    output logic              dio_oe_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              conv_start_o,
    output logic [WORD_W-1:0] wr_word_o,
    output logic              wr_valid_o,
    output logic              wr_cal_o
);
    localparam int BIT_CW = $clog2(WORD_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(WORD_W - 1);

    typedef struct packed {
        pin_dir_e           dir;
        logic [BIT_CW-1:0]  bit_cnt;
        logic [CNT_W-1:0]   burst_left;
        logic [WORD_W-1:0]  ctrl;
        logic               conv;
        logic [WORD_W-1:0]  wr_word;
        logic               wr_valid;
        logic               wr_cal;
        logic               oe;
        logic               sclk_prev;
    } port_t;

    port_t st_d, st_q;

    logic              sclk_s, sync_s, din_s;
    logic              sclk_rise, sclk_fall;
    logic              rx_en, tx_load, tx_shift;
    logic [WORD_W-1:0] rx_word;
    logic [CNT_W-1:0]  req_cnt;

    twp_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, sync_n_i, dio_i}),
        .sync_o  ({sclk_s, sync_s, din_s})
    );

    twp_shift #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rx_bit    (din_s),
        .tx_load   (tx_load),
        .tx_data   (rd_data_i),
        .tx_shift  (tx_shift),
        .rx_next_o (rx_word),
        .tx_bit_o  (dio_o)
    );

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;
    assign req_cnt   = rx_word[CNT_HI:CNT_LO];

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.conv      = 1'b0;
        st_d.wr_valid  = 1'b0;
        st_d.wr_cal    = 1'b0;
        rx_en          = 1'b0;
        tx_load        = 1'b0;
        tx_shift       = 1'b0;

        if (sync_s) begin
            st_d.bit_cnt = '0;
        end else begin
            if (sclk_fall && st_q.dir == DIR_OUT) tx_shift = 1'b1;
            if (sclk_rise) begin
                rx_en = (st_q.dir == DIR_IN);
                if (st_q.bit_cnt != LAST_BIT) begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end else begin
                    st_d.bit_cnt = '0;
                    if (st_q.dir == DIR_IN) begin
                        st_d.wr_valid = 1'b1;
                        st_d.wr_word  = rx_word;
                        if (st_q.burst_left != '0) begin
                            st_d.wr_cal     = 1'b1;
                            st_d.burst_left = st_q.burst_left - 1'b1;
                            if (st_q.burst_left == CNT_W'(1)) begin
                                st_d.dir = DIR_OUT;
                                tx_load  = 1'b1;
                            end
                        end else if (rx_word[MODE_POS]) begin
                            st_d.ctrl = rx_word;
                            st_d.conv = rx_word[CONV_POS];
                            st_d.burst_left = req_cnt;
                            if (req_cnt == '0 || rx_word[BDIR_POS]) begin
                                st_d.dir = DIR_OUT;
                                tx_load  = 1'b1;
                            end
                        end else begin
                            st_d.dir = DIR_OUT;
                            tx_load  = 1'b1;
                        end
                    end else begin
                        if (st_q.burst_left != '0) begin
                            st_d.burst_left = st_q.burst_left - 1'b1;
                            if (st_q.burst_left == CNT_W'(1)) st_d.dir = DIR_IN;
                            else                              tx_load  = 1'b1;
                        end else begin
                            st_d.dir = DIR_IN;
                        end
                    end
                end
            end
        end
        st_d.oe = (st_d.dir == DIR_OUT) && !sync_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.dir       <= DIR_IN;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dio_oe_o     = st_q.oe;
    assign ctrl_o       = st_q.ctrl;
    assign conv_start_o = st_q.conv;
    assign wr_word_o    = st_q.wr_word;
    assign wr_valid_o   = st_q.wr_valid;
    assign wr_cal_o     = st_q.wr_cal;

    // R3
    sync_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |=> !dio_oe_o);

    // R8
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R7
    ctrl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> ctrl_o[MODE_POS]);

    // R9
    burst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.burst_left != '0) && ($past(st_q.burst_left) != '0)
        |-> st_q.dir == $past(st_q.dir));

    // R10
    cal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cal_o |-> wr_valid_o && !conv_start_o);

    // R4
    dout_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dio_o) |-> $past(tx_shift));
endmodule

// File: tb/twp_port_bench.sv
module twp_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b1;
    logic        sync_n_i = 1'b1;
    logic        dio_i = 1'b0;
    logic        dio_o, dio_oe_o;
    logic [15:0] rd_data_i = '0;
    logic [15:0] ctrl_o, wr_word_o;
    logic        conv_start_o, wr_valid_o, wr_cal_o;

    int vectors = 0;
    int fails = 0;
    int conv_cnt = 0;
    int exp_conv = 0;
    logic [15:0] last_wr = '0;
    logic        last_cal = 1'b0;
    bit          oe_err = 1'b0;

    always #2 clk = ~clk;

    twp_port u_twp_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sync_n_i(sync_n_i),
        .dio_i(dio_i), .dio_o(dio_o), .dio_oe_o(dio_oe_o),
        .rd_data_i(rd_data_i), .ctrl_o(ctrl_o), .conv_start_o(conv_start_o),
        .wr_word_o(wr_word_o), .wr_valid_o(wr_valid_o), .wr_cal_o(wr_cal_o)
    );

    always @(posedge clk) begin
        if (conv_start_o) conv_cnt <= conv_cnt + 1;
        if (wr_valid_o) begin
            last_wr  <= wr_word_o;
            last_cal <= wr_cal_o;
        end
    end

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w, input bit pulsed, input int nbits);
        if (pulsed) begin sync_n_i = 1'b0; half(); end
        for (int b = 15; b > 15 - nbits; b--) begin
            sclk_i = 1'b0; dio_i = w[b];
            half();
            if (dio_oe_o) oe_err = 1'b1;
            sclk_i = 1'b1;
            half();
        end
        if (pulsed) begin sync_n_i = 1'b1; half(); end
    endtask

    task automatic recv_word(output logic [15:0] r, input bit pulsed);
        if (pulsed) begin sync_n_i = 1'b0; half(); end
        for (int b = 15; b >= 0; b--) begin
            sclk_i = 1'b0;
            half();
            r[b] = dio_o;
            if (!dio_oe_o) oe_err = 1'b1;
            sclk_i = 1'b1;
            half();
        end
        if (pulsed) begin sync_n_i = 1'b1; half(); end
    endtask

    task automatic probe_oe(input string req, input logic exp);
        sync_n_i = 1'b0; half();
        chk(req, dio_oe_o, exp);
        sync_n_i = 1'b1; half();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] r, w, rd, cw;
        repeat (5) @(negedge clk);
        // R12 reset state
        chk("R12 oe", dio_oe_o, 0);
        chk("R12 ctrl", ctrl_o, 0);
        chk("R12 flags", {conv_start_o, wr_valid_o, wr_cal_o}, 0);
        rst_n = 1'b1;
        half();
        chk("R12 oe after reset", dio_oe_o, 0);

        // R1 R2 R3 R4 R5 R7 R8: sweep over bit positions, pulsed framing
        for (int i = 0; i < 16; i++) begin
            w  = 16'h8000 | (((16'h0001 << i) | (16'(i) * 16'h0101)) & 16'h47FF);
            rd = (16'h0001 << i) ^ (16'(i) * 16'h1357);
            rd_data_i = rd;
            oe_err = 1'b0;
            send_word(w, 1'b1, 16);
            chk("R2 oe low during write", oe_err, 0);
            chk("R1 write word", last_wr, w);
            chk("R1 not burst", last_cal, 0);
            chk("R7 ctrl load", ctrl_o, w);
            if (w[14]) exp_conv++;
            chk("R8 conv count", conv_cnt, exp_conv);
            chk("R3 oe with sync high", dio_oe_o, 0);
            rd_data_i = ~rd;
            recv_word(r, 1'b1);
            chk("R4 read word", r, rd);
            chk("R2 oe during read", oe_err, 0);
            probe_oe("R5 back to input", 1'b0);
        end

        // R7 invalid write: no ctrl update, no conv, no burst
        cw = ctrl_o;
        rd_data_i = 16'h5A3C;
        send_word(16'h7ABC, 1'b1, 16);
        chk("R7 invalid word seen", last_wr, 16'h7ABC);
        chk("R7 ctrl kept", ctrl_o, cw);
        chk("R7 no conv", conv_cnt, exp_conv);
        recv_word(r, 1'b1);
        chk("R7 read follows", r, 16'h5A3C);
        probe_oe("R7 no burst opened", 1'b0);

        // R6 SYNC tied low, alternating words
        sync_n_i = 1'b0; half();
        for (int k = 0; k < 4; k++) begin
            w  = 16'h8000 | (16'(k) * 16'h0231);
            rd = 16'hC001 ^ (16'(k) * 16'h0F0F);
            rd_data_i = rd;
            oe_err = 1'b0;
            send_word(w, 1'b0, 16);
            chk("R6 write tied", last_wr, w);
            chk("R6 oe after write", dio_oe_o, 1);
            recv_word(r, 1'b0);
            chk("R6 read tied", r, rd);
            chk("R6 no tristate", oe_err, 0);
            chk("R6 oe after read", dio_oe_o, 0);
        end
        sync_n_i = 1'b1; half();

        // R11 partial write discarded
        send_word(16'hFFFF, 1'b1, 7);
        w = 16'h8421;
        send_word(w, 1'b1, 16);
        chk("R11 realigned word", ctrl_o, w);
        recv_word(r, 1'b1);

        // R9 read burst of 3
        cw = 16'h8000 | 16'h3000 | 16'h0800 | 16'h0055;
        rd_data_i = 16'hA000;
        send_word(cw, 1'b1, 16);
        chk("R9 ctrl", ctrl_o, cw);
        for (int j = 0; j < 3; j++) begin
            rd_data_i = 16'hA000 + 16'(j + 1) * 16'h0111;
            oe_err = 1'b0;
            recv_word(r, 1'b1);
            chk("R9 burst word", r, 16'hA000 + 16'(j) * 16'h0111);
            chk("R9 oe held", oe_err, 0);
        end
        probe_oe("R9 input after burst", 1'b0);

        // R10 write burst of 2, with R11 partial inside
        cw = 16'h8000 | 16'h2000 | 16'h0123;
        rd_data_i = 16'h0F5E;
        send_word(cw, 1'b1, 16);
        chk("R10 ctrl", ctrl_o, cw);
        send_word(16'h0000, 1'b1, 5);
        send_word(16'hFFFF, 1'b1, 16);
        chk("R10 cal word 1", {last_cal, last_wr}, {1'b1, 16'hFFFF});
        probe_oe("R11 burst kept input", 1'b0);
        send_word(16'h8ACE, 1'b1, 16);
        chk("R10 cal word 2", {last_cal, last_wr}, {1'b1, 16'h8ACE});
        chk("R10 ctrl untouched", ctrl_o, cw);
        chk("R10 no conv", conv_cnt, exp_conv);
        recv_word(r, 1'b1);
        chk("R10 read after burst", r, 16'h0F5E);
        probe_oe("R10 input after read", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule